// File: doc/BRIEF.md
# 8x8 Constant-Matrix Multiply Stage

This block is one pass of a separable two-dimensional transform on 8x8 tiles. It takes in one signed sample per cycle. Every run of eight consecutive samples forms an input vector. The block multiplies that vector by a fixed 8x8 coefficient matrix, picked from one of four banks: forward cosine transform, inverse cosine transform, a three-tap smoothing kernel, or the identity. It then streams out the eight results of the product, one per cycle. A full tile of 64 samples is processed in 64 cycles, and consecutive tiles may follow with no idle cycle between them.

Every product is kept at full width, and the eight products are summed exactly. A field selector then reduces each sum to the width the caller asks for. It discards a programmable number of low bits, rounding half upwards, and saturates the remainder to a programmable number of signed bits. The block captures the bank, the discard count and the output width with the first sample of a tile. Two instances with a transposing store between them make a complete 2-D stage.

Top module: `mxs_matmul_stage`

## Requirements
- R1: After a synchronous active-low reset, `out_vld_o`, `out_first_o` and `out_data_o` are all zero.
- R2: While the block is idle, a high `start_i` marks the current `smp_i` as sample 0 of a 64-sample tile. For the 63 cycles that follow, every cycle carries a sample of that tile, and `start_i` is ignored.
- R3: Sample p of a tile (p = 8j + m) is element m of input vector j. Output element k of vector j appears as tile sample 8j + k, exactly 8 clock edges after the edge that captured input sample 8j + k. `out_vld_o` is high for the 64 output samples, and `out_first_o` is high only with output sample 0.
- R4: Bank code 0 (forward) uses coefficient C[k][m] = round(4096 * sqrt(2) * c(k) * cos((2m+1)k*pi/16)), where c(0) = 1/sqrt(2) and c(k) = 1 otherwise. The entries are therefore ±4096, ±5681, ±5352, ±4816, ±3218, ±2217 and ±1130, and row 0 is all 4096.
- R5: Bank code 1 (inverse) uses the transpose of the forward matrix: C[k][m] = forward[m][k].
- R6: Bank code 2 (smoothing) has rows 0 and 7 equal to identity rows, with 4096 on the diagonal. Each row k from 1 to 6 holds 1024 at column k-1, 2048 at column k and 1024 at column k+1, and zero elsewhere.
- R7: Bank code 3 (identity) holds 4096 on the diagonal and zero elsewhere.
- R8: Each output is formed from the exact 33-bit sum of the eight products of 16-bit samples and 14-bit coefficients, with no intermediate rounding.
- R9: The selector discards the low D = `drop_i` bits (arithmetic shift right). It adds one when bit D-1 of the sum is set. When D = 0, it passes the sum unchanged.
- R10: The rounded value is saturated to W = `keep_i` signed bits, giving a range of -2^(W-1) to 2^(W-1)-1, and is sign-extended onto `out_data_o`.
- R11: The bank, D and W are captured with sample 0 of a tile. Changes on `bank_i`, `drop_i` or `keep_i` during the other 63 cycles do not change that tile's outputs.
- R12: Tiles started back to back give 128 contiguous valid output samples. When `out_vld_o` is low, `out_data_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Tile start marker, sampled only while idle |
| bank_i | input | 2 | Coefficient bank: 0 forward, 1 inverse, 2 smoothing, 3 identity |
| drop_i | input | 6 | Number of low sum bits rounded away |
| keep_i | input | 5 | Signed output width after saturation |
| smp_i | input | 16 | Signed input sample |
| out_vld_o | output | 1 | Output sample valid |
| out_first_o | output | 1 | First output sample of a tile |
| out_data_o | output | 16 | Signed output sample |

## Verification
The embedded properties assume `keep_i` between 1 and 16 and `drop_i` below 33 whenever a tile starts. They also assume that, outside reset, the caller supplies a real sample on each of the 63 cycles after a start. The bench keeps every configuration it captures inside these ranges. It deliberately toggles `start_i` and randomises the configuration inputs only in the middle of a tile, where the block must ignore them. Input magnitudes are chosen per bank so that some scenarios stay clear of saturation and others drive far into it.

// File: rtl/mxs_pkg.sv
// Shared constants, the bank encoding and the coefficient generator for the
// constant-matrix multiply stage. Coefficients are 14-bit signed values with
// 12 fractional bits (4096 represents 1.0).
package mxs_pkg;

    localparam int VEC       = 8;
    localparam int BLK       = VEC * VEC;
    localparam int COEF_W    = 14;
    localparam int COEF_ONE  = 4096;
    localparam int LATENCY   = VEC;
    localparam int IDX_W     = $clog2(VEC);
    localparam int POS_W     = $clog2(BLK);

    typedef enum logic [1:0] {
        BANK_FWD    = 2'd0,
        BANK_INV    = 2'd1,
        BANK_SMOOTH = 2'd2,
        BANK_IDENT  = 2'd3
    } bank_e;

    // Scaled sqrt(2)*cos(p*pi/16) for any integer phase p, by octant folding.
    function automatic int cos_term(input int p);
        int q;
        int r;
        int v;
        bit neg;
        q = p % 32;
        if (q <= 8)       begin r = q;      neg = 1'b0; end
        else if (q <= 16) begin r = 16 - q; neg = 1'b1; end
        else if (q <= 24) begin r = q - 16; neg = 1'b1; end
        else              begin r = 32 - q; neg = 1'b0; end
        case (r)
            0:       v = 5793;
            1:       v = 5681;
            2:       v = 5352;
            3:       v = 4816;
            4:       v = 4096;
            5:       v = 3218;
            6:       v = 2217;
            7:       v = 1130;
            default: v = 0;
        endcase
        return neg ? -v : v;
    endfunction

    // Forward cosine-transform entry: row k (frequency), column m (sample).
    function automatic int fwd_term(input int k, input int m);
        if (k == 0) return COEF_ONE;
        return cos_term(k * (2 * m + 1));
    endfunction

    // Coefficient of the selected bank at (output row, input column).
    function automatic logic signed [COEF_W-1:0] coef_val(input logic [1:0] bank,
                                                           input int row,
                                                           input int col);
        int v;
        case (bank_e'(bank))
            BANK_FWD: v = fwd_term(row, col);
            BANK_INV: v = fwd_term(col, row);
            BANK_SMOOTH: begin
                if (row == 0 || row == VEC - 1)
                    v = (col == row) ? COEF_ONE : 0;
                else if (col == row)
                    v = COEF_ONE / 2;
                else if (col == row - 1 || col == row + 1)
                    v = COEF_ONE / 4;
                else
                    v = 0;
            end
            default: v = (col == row) ? COEF_ONE : 0;
        endcase
        return COEF_W'(v);
    endfunction

endpackage

// File: rtl/mxs_seq.sv
// Tile sequencer. Accepts a start marker only while idle, then treats the
// next 63 cycles as samples of the same tile. Captures the bank and field
// selector settings with sample 0; assumes the caller feeds one sample per
// cycle for the whole tile.
module mxs_seq
    import mxs_pkg::*;
#(
    parameter int DROP_W = 6,
    parameter int KEEP_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        bank_i,
    input  logic [DROP_W-1:0] drop_i,
    input  logic [KEEP_W-1:0] keep_i,
    output logic              accept_o,
    output logic [POS_W-1:0]  pos_o,
    output logic [1:0]        bank_o,
    output logic [DROP_W-1:0] drop_o,
    output logic [KEEP_W-1:0] keep_o
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(BLK - 1);

    logic              busy;
    logic [POS_W-1:0]  cnt;
    logic [1:0]        bank_q;
    logic [DROP_W-1:0] drop_q;
    logic [KEEP_W-1:0] keep_q;
    logic              launch;

    // Start is honoured only between tiles.
    assign launch   = start_i && !busy;
    assign accept_o = launch || busy;
    assign pos_o    = launch ? '0 : cnt;
    assign bank_o   = launch ? bank_i : bank_q;
    assign drop_o   = drop_q;
    assign keep_o   = keep_q;

    // Tile position counter and configuration capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cnt    <= '0;
            bank_q <= '0;
            drop_q <= '0;
            keep_q <= '0;
        end else if (launch) begin
            busy   <= 1'b1;
            cnt    <= POS_W'(1);
            bank_q <= bank_i;
            drop_q <= drop_i;
            keep_q <= keep_i;
        end else if (busy) begin
            if (cnt == LAST_POS) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R2: a started tile runs all of its 64 cycles.
    a_r2_tile_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt != LAST_POS) |=> busy);

    // R11: captured settings hold for the rest of the tile.
    a_r11_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt != LAST_POS) |=> ($stable(bank_q) && $stable(drop_q) && $stable(keep_q)));

endmodule

// File: rtl/mxs_mac.sv
// Lane-parallel multiply-accumulate array. When input sample m of a vector
// arrives, every lane k adds coef[k][m] * sample to its own accumulator, so
// the eight exact sums are complete together on the edge after the eighth
// sample. Assumes sample index 0 restarts every vector.
module mxs_mac
    import mxs_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int ACC_W = 33
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    accept_i,
    input  logic [IDX_W-1:0]        idx_i,
    input  logic                    col_first_i,
    input  logic [1:0]              bank_i,
    input  logic signed [IN_W-1:0]  smp_i,
    output logic signed [ACC_W-1:0] acc_o [VEC],
    output logic                    done_o,
    output logic                    done_first_o
);

    localparam int PROD_W = IN_W + COEF_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(VEC - 1);

    for (genvar k = 0; k < VEC; k++) begin : g_lane
        logic signed [COEF_W-1:0] cf;
        logic signed [PROD_W-1:0] prod;

        assign cf   = coef_val(bank_i, k, int'(idx_i));
        assign prod = smp_i * cf;

        // Restart on element 0, otherwise add the exact product.
        always_ff @(posedge clk) begin
            if (!rst_n)
                acc_o[k] <= '0;
            else if (accept_i)
                acc_o[k] <= (idx_i == '0) ? ACC_W'(prod) : acc_o[k] + ACC_W'(prod);
        end
    end

    // Flags that the accumulators hold a finished vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o       <= 1'b0;
            done_first_o <= 1'b0;
        end else begin
            done_o       <= accept_i && (idx_i == LAST_IDX);
            done_first_o <= accept_i && (idx_i == LAST_IDX) && col_first_i;
        end
    end

    // R3: a finished vector follows an accepted last element.
    a_r3_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(accept_i && idx_i == LAST_IDX));

endmodule

// File: rtl/mxs_rsat.sv
// Field selector for one lane: arithmetic shift by the discard count, add
// one when the top discarded bit is set, then clamp to the requested signed
// width. Purely combinational; assumes drop_i < ACC_W.
module mxs_rsat #(
    parameter int ACC_W  = 33,
    parameter int OUT_W  = 16,
    parameter int DROP_W = 6,
    parameter int KEEP_W = 5
) (
    input  logic signed [ACC_W-1:0] acc_i,
    input  logic [DROP_W-1:0]       drop_i,
    input  logic [KEEP_W-1:0]       keep_i,
    output logic signed [OUT_W-1:0] val_o
);

    localparam logic signed [ACC_W:0] ONE_S = (ACC_W+1)'(1);

    logic signed [ACC_W-1:0] shifted;
    logic                    half;
    logic signed [ACC_W:0]   rounded;
    logic [KEEP_W-1:0]       k_eff;
    logic signed [ACC_W:0]   hi;
    logic signed [ACC_W:0]   lo;
    logic signed [ACC_W:0]   sat;

    // Round half upwards on the discarded field.
    always_comb begin
        shifted = acc_i >>> drop_i;
        if (drop_i != '0 && drop_i <= DROP_W'(ACC_W))
            half = acc_i[drop_i - 1'b1];
        else
            half = 1'b0;
        rounded = $signed({shifted[ACC_W-1], shifted}) + $signed({{ACC_W{1'b0}}, half});
    end

    // Clamp to the signed range of the requested width.
    always_comb begin
        if (keep_i > KEEP_W'(OUT_W))
            k_eff = KEEP_W'(OUT_W);
        else if (keep_i == '0)
            k_eff = KEEP_W'(1);
        else
            k_eff = keep_i;
        hi = (ONE_S <<< (k_eff - 1'b1)) - ONE_S;
        lo = -hi - ONE_S;
        if (rounded > hi)
            sat = hi;
        else if (rounded < lo)
            sat = lo;
        else
            sat = rounded;
        val_o = sat[OUT_W-1:0];
    end

endmodule

// File: rtl/mxs_ser.sv
// Output serializer. Loads eight selected results at once and presents them
// one per cycle, lane 0 first, shifting zeros in behind so the port reads
// zero whenever nothing is valid. A load may land on the last shift cycle.
module mxs_ser
    import mxs_pkg::*;
#(
    parameter int OUT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_i,
    input  logic                    load_first_i,
    input  logic signed [OUT_W-1:0] val_i [VEC],
    output logic                    out_vld_o,
    output logic                    out_first_o,
    output logic signed [OUT_W-1:0] out_data_o
);

    localparam int LEFT_W = $clog2(VEC + 1);

    logic signed [OUT_W-1:0] sh [VEC];
    logic [LEFT_W-1:0]       left;
    logic                    first_q;

    // Load a vector or shift the next element out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < VEC; i++) sh[i] <= '0;
            left    <= '0;
            first_q <= 1'b0;
        end else if (load_i) begin
            for (int i = 0; i < VEC; i++) sh[i] <= val_i[i];
            left    <= LEFT_W'(VEC);
            first_q <= load_first_i;
        end else if (left != '0) begin
            for (int i = 0; i < VEC - 1; i++) sh[i] <= sh[i+1];
            sh[VEC-1] <= '0;
            left      <= left - 1'b1;
            first_q   <= 1'b0;
        end
    end

    assign out_vld_o   = (left != '0);
    assign out_first_o = first_q;
    assign out_data_o  = sh[0];

    // R12: the data port is quiet when nothing is valid.
    a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld_o |-> (out_data_o == '0));

    // R3: the first-sample marker only travels with valid data.
    a_r3_first_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_first_o |-> out_vld_o);

endmodule

// File: rtl/mxs_matmul_stage.sv
// One pass of a separable 8x8 transform: tiles of 64 samples in, each group
// of eight multiplied by a constant matrix from the selected bank, exact
// sums rounded and saturated to the captured field, 64 samples out with a
// fixed latency of mxs_pkg::LATENCY edges. Assumes one sample per cycle
// during a tile.
module mxs_matmul_stage
    import mxs_pkg::*;
#(
    parameter int IN_W   = 16,
    parameter int OUT_W  = 16,
    localparam int ACC_W  = IN_W + COEF_W + $clog2(VEC),
    localparam int DROP_W = $clog2(ACC_W),
    localparam int KEEP_W = $clog2(OUT_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        bank_i,
    input  logic [DROP_W-1:0] drop_i,
    input  logic [KEEP_W-1:0] keep_i,
    input  logic [IN_W-1:0]   smp_i,
    output logic              out_vld_o,
    output logic              out_first_o,
    output logic [OUT_W-1:0]  out_data_o
);

    logic                    accept;
    logic [POS_W-1:0]        pos;
    logic [1:0]              bank_eff;
    logic [DROP_W-1:0]       drop_q;
    logic [KEEP_W-1:0]       keep_q;
    logic signed [ACC_W-1:0] acc [VEC];
    logic                    done;
    logic                    done_first;
    logic signed [OUT_W-1:0] rs_val [VEC];
    logic signed [OUT_W-1:0] out_s;
    logic                    col_first;

    assign col_first = (pos[POS_W-1:IDX_W] == '0);

    mxs_seq #(.DROP_W(DROP_W), .KEEP_W(KEEP_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .bank_i   (bank_i),
        .drop_i   (drop_i),
        .keep_i   (keep_i),
        .accept_o (accept),
        .pos_o    (pos),
        .bank_o   (bank_eff),
        .drop_o   (drop_q),
        .keep_o   (keep_q)
    );

    mxs_mac #(.IN_W(IN_W), .ACC_W(ACC_W)) u_mac (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept_i     (accept),
        .idx_i        (pos[IDX_W-1:0]),
        .col_first_i  (col_first),
        .bank_i       (bank_eff),
        .smp_i        ($signed(smp_i)),
        .acc_o        (acc),
        .done_o       (done),
        .done_first_o (done_first)
    );

    for (genvar k = 0; k < VEC; k++) begin : g_sel
        mxs_rsat #(.ACC_W(ACC_W), .OUT_W(OUT_W), .DROP_W(DROP_W), .KEEP_W(KEEP_W)) u_rsat (
            .acc_i  (acc[k]),
            .drop_i (drop_q),
            .keep_i (keep_q),
            .val_o  (rs_val[k])
        );
    end

    mxs_ser #(.OUT_W(OUT_W)) u_ser (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (done),
        .load_first_i (done_first),
        .val_i        (rs_val),
        .out_vld_o    (out_vld_o),
        .out_first_o  (out_first_o),
        .out_data_o   (out_s)
    );

    assign out_data_o = out_s;

    // R3: tile output begins a fixed latency after tile sample 0 is taken.
    a_r3_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_first_o |-> $past(accept && pos == '0, LATENCY + 1));

endmodule

// File: tb/mxs_matmul_stage_tb.sv
module mxs_matmul_stage_tb;

    localparam int IN_W  = 16;
    localparam int OUT_W = 16;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [1:0]         bank = '0;
    logic [5:0]         drop = '0;
    logic [4:0]         keep = 5'd16;
    logic [IN_W-1:0]    smp = '0;
    logic               out_vld;
    logic               out_first;
    logic [OUT_W-1:0]   out_data;

    int n_vec = 0;
    int n_bad = 0;
    int xin [2][64];
    int c_bank [2];
    int c_drop [2];
    int c_keep [2];
    bit noise = 1'b0;

    always #10 clk = ~clk;

    mxs_matmul_stage u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .bank_i      (bank),
        .drop_i      (drop),
        .keep_i      (keep),
        .smp_i       (smp),
        .out_vld_o   (out_vld),
        .out_first_o (out_first),
        .out_data_o  (out_data)
    );

    task automatic chk(input longint act, input longint exp, input string tag);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int rnd_real(input real v);
        if (v >= 0.0) return $rtoi(v + 0.5);
        return -$rtoi(-v + 0.5);
    endfunction

    // Coefficients straight from the requirement formulas.
    function automatic int b_fwd(input int k, input int m);
        real ck;
        ck = (k == 0) ? 1.0 / $sqrt(2.0) : 1.0;
        return rnd_real(4096.0 * $sqrt(2.0) * ck * $cos((2.0 * m + 1.0) * k * 3.14159265358979 / 16.0));
    endfunction

    function automatic int b_coef(input int bk, input int r, input int c);
        case (bk)
            0: return b_fwd(r, c);
            1: return b_fwd(c, r);
            2: begin
                if (r == 0 || r == 7) return (c == r) ? 4096 : 0;
                if (c == r) return 2048;
                if (c == r - 1 || c == r + 1) return 1024;
                return 0;
            end
            default: return (c == r) ? 4096 : 0;
        endcase
    endfunction

    function automatic longint b_sel(input longint a, input int d, input int w);
        longint t;
        longint hi;
        t = a >>> d;
        if (d > 0 && a[d-1]) t = t + 1;
        hi = (64'sd1 <<< (w - 1)) - 1;
        if (t > hi) t = hi;
        if (t < -hi - 1) t = -hi - 1;
        return t;
    endfunction

    function automatic longint b_expect(input int b, input int p);
        longint s;
        int j;
        int k;
        j = p / 8;
        k = p % 8;
        s = 0;
        for (int m = 0; m < 8; m++)
            s += longint'(b_coef(c_bank[b], k, m)) * longint'(xin[b][j*8 + m]);
        return b_sel(s, c_drop[b], c_keep[b]);
    endfunction

    function automatic int rnd_w(input int w);
        return int'($urandom % (1 << w)) - (1 << (w - 1));
    endfunction

    // Drive nblk tiles back to back and check every output sample.
    task automatic stream(input int nblk, input string tag);
        fork
            begin
                for (int i = 0; i < nblk * 64; i++) begin
                    @(negedge clk);
                    if (i % 64 == 0) begin
                        start = 1'b1;
                        bank  = 2'(c_bank[i/64]);
                        drop  = 6'(c_drop[i/64]);
                        keep  = 5'(c_keep[i/64]);
                    end else if (noise) begin
                        start = 1'($urandom % 2);
                        bank  = 2'($urandom % 4);
                        drop  = 6'($urandom % 33);
                        keep  = 5'(1 + $urandom % 16);
                    end else begin
                        start = 1'b0;
                    end
                    smp = IN_W'(xin[i/64][i%64]);
                end
                @(negedge clk);
                start = 1'b0;
                smp   = '0;
            end
            begin
                @(negedge clk);
                repeat (8) @(negedge clk);
                chk(longint'(out_vld), 0, {tag, " R3 latency: valid one cycle early"});
                @(negedge clk);
                for (int i = 0; i < nblk * 64; i++) begin
                    chk(longint'(out_vld), 1, {tag, " R3 valid"});
                    chk(longint'(out_first), (i % 64 == 0) ? 1 : 0, {tag, " R3 first marker"});
                    chk(longint'($signed(out_data)), b_expect(i / 64, i % 64),
                        $sformatf("%s data at sample %0d", tag, i));
                    @(negedge clk);
                end
                for (int i = 0; i < 2; i++) begin
                    chk(longint'(out_vld), 0, {tag, " R12 idle valid"});
                    chk(longint'(out_data), 0, {tag, " R12 idle data"});
                    @(negedge clk);
                end
            end
        join
    endtask

    task automatic set_cfg(input int b, input int bk, input int d, input int w);
        c_bank[b] = bk;
        c_drop[b] = d;
        c_keep[b] = w;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(longint'(out_vld), 0, "R1 reset valid");
        chk(longint'(out_first), 0, "R1 reset first");
        chk(longint'(out_data), 0, "R1 reset data");
    endtask

    task automatic t_forward();
        for (int p = 0; p < 64; p++) xin[0][p] = rnd_w(9);
        set_cfg(0, 0, 8, 16);
        stream(1, "R4 R8 forward");
    endtask

    task automatic t_inverse();
        for (int p = 0; p < 64; p++) xin[0][p] = rnd_w(12);
        set_cfg(0, 1, 8, 16);
        stream(1, "R5 inverse");
    endtask

    task automatic t_smooth();
        for (int p = 0; p < 64; p++) xin[0][p] = rnd_w(9);
        set_cfg(0, 2, 5, 16);
        stream(1, "R6 smoothing");
    endtask

    task automatic t_ident_round();
        for (int p = 0; p < 64; p++) xin[0][p] = (p % 16) - 8;
        set_cfg(0, 3, 13, 16);
        stream(1, "R7 R9 identity half rounding");
    endtask

    task automatic t_no_drop();
        for (int p = 0; p < 64; p++) xin[0][p] = (p % 15) - 7;
        set_cfg(0, 3, 0, 16);
        stream(1, "R9 zero discard");
    endtask

    task automatic t_saturate();
        for (int p = 0; p < 64; p++) xin[0][p] = (p % 3 == 0) ? 32767 : rnd_w(16);
        set_cfg(0, 0, 8, 12);
        stream(1, "R10 saturation");
    endtask

    task automatic t_exact_wide();
        for (int p = 0; p < 64; p++) xin[0][p] = (p % 2 == 0) ? -32768 : rnd_w(16);
        set_cfg(0, 1, 19, 12);
        stream(1, "R8 R10 wide sums");
    endtask

    task automatic t_back_to_back();
        for (int p = 0; p < 64; p++) xin[0][p] = rnd_w(9);
        for (int p = 0; p < 64; p++) xin[1][p] = rnd_w(12);
        set_cfg(0, 2, 5, 9);
        set_cfg(1, 1, 8, 16);
        noise = 1'b1;
        stream(2, "R2 R11 R12 back to back");
        noise = 1'b0;
    endtask

    initial begin : main
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_forward();
        t_inverse();
        t_smooth();
        t_ident_round();
        t_no_drop();
        t_saturate();
        t_exact_wide();
        t_back_to_back();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule